// File: doc/BRIEF.md
# Two-Wire Serial Slave Byte Reader

This block is the read half of a two-wire serial slave that sits in front of a small byte array. It watches the clock and data lines of the bus and finds Start, repeated Start and Stop conditions. It compares the 7-bit address in each address byte with its own address. When a byte is due to it, the block shifts the byte out on the data line through an open-drain enable. The array is a register file inside the block, loaded with a fixed pattern at reset. The block cannot write to it.

A word pointer survives from one transaction to the next. A host has three ways to read. It can send only a read-direction address frame, and then gets the byte the pointer names. It can first send a write-direction frame that carries one word-address byte, which loads the pointer, and then read after a repeated Start. In either case, as long as the host acknowledges each byte, the block keeps sending the following bytes. The pointer wraps over the whole array. Because reset clears the pointer, a bare read right after reset dumps the array from location 0.

Top module: `i2crd_top`

## Requirements
- R1: After reset the block does not drive the data line, the pointer is 0, and array location i holds (i*29+7) mod 256.
- R2: A Start is the data line falling while the clock line is high. The address byte that follows is shifted MSB first: seven address bits, then a direction bit (1 = read). If the seven bits equal the slave address, the block pulls the data line low during the ninth clock.
- R3: Read data goes out MSB first, one bit per clock. During the ninth clock the block releases the data line and takes the host's bit on the ninth rising edge: 0 means acknowledge, and the next byte follows.
- R4: After a host NACK the block does not drive the data line again until the next Start. After a Stop it is idle.
- R5: After each byte sent, the pointer advances by one. From location 2^AW-1 it wraps to 0 and the data keeps coming.
- R6: A read frame with no word address first returns the byte at the pointer, which is the location after the last byte sent.
- R7: In a matching write-direction frame, the address byte and the word-address byte that follows are both acknowledged. The low AW bits of the word-address byte load the pointer. A repeated Start and a read frame then return data from that location.
- R8: A read frame issued right after reset returns locations 0, 1, 2, and so on.
- R9: An address byte that does not match gets no acknowledge. The block then leaves the data line alone until the next Start or Stop, and the pointer does not change.
- R10: The data-line enable changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench covers each way a read can start. A bare read after reset shows that the pointer starts at zero. A second bare read shows that the pointer was kept and advanced. Random reads to a middle location and to a word-address byte with its upper bits set separate a real pointer load from a pointer that just keeps counting. A long burst that crosses the top of the array checks the wrap. Frames with a foreign address, in both directions, check that the slave stays silent and that its pointer does not move. An extra byte clocked after a NACK shows that the line stays released.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_AACK  = 3'd2,
        ST_WADDR = 3'd3,
        ST_WACK  = 3'd4,
        ST_TX    = 3'd5,
        ST_TACK  = 3'd6,
        ST_SKIP  = 3'd7
    } st_e;

endpackage

// File: rtl/i2crd_busin.sv
// Brings the two bus lines into the clock domain and derives edge and
// condition pulses from the synchronised values.
module i2crd_busin #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic              scl_prev_q, sda_prev_q;
    logic              scl_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q   <= '1;
            sda_sh_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sh_q   <= {scl_sh_q[STAGES-2:0], scl_i};
            sda_sh_q   <= {sda_sh_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_sh_q[STAGES-1];
            sda_prev_q <= sda_sh_q[STAGES-1];
        end
    end

    assign scl_c    = scl_sh_q[STAGES-1];
    assign sda_s    = sda_sh_q[STAGES-1];
    assign scl_rise = scl_c & ~scl_prev_q;
    assign scl_fall = ~scl_c & scl_prev_q;
    // Data moving while the clock stays high marks a bus condition.
    assign start_p  = scl_c & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_p   = scl_c & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2crd_array.sv
// Byte register file loaded with a computed pattern at reset, one
// registered read port.
module i2crd_array #(
    parameter int AW      = 5,
    parameter int PAT_MUL = 29,
    parameter int PAT_ADD = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cell_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [7:0] INIT = 8'((g * PAT_MUL + PAT_ADD) % 256);
        logic [7:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= INIT;
            else        val_q <= val_q;
        end
        assign cell_w[g] = val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= cell_w[rd_addr];
    end

endmodule

// File: rtl/i2crd_top.sv
module i2crd_top
    import i2crd_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h52,
    parameter int         AW       = 5,
    parameter int         PAT_MUL  = 29,
    parameter int         PAT_ADD  = 7,
    parameter int         SYNC_STG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam logic [AW-1:0] PTR_ONE = AW'(1);
    localparam logic [3:0]    BITS    = 4'd8;

    typedef struct packed {
        st_e           st;
        logic [7:0]    sh;
        logic [3:0]    cnt;
        logic [AW-1:0] ptr;
        logic          rw;
        logic          mack;
        logic          oe;
    } regs_t;

    regs_t      d, q;
    logic       sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [7:0] rd_data;
    st_e        cur_st;
    logic [AW-1:0] cur_ptr;

    i2crd_busin #(.STAGES(SYNC_STG)) u_busin (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    i2crd_array #(.AW(AW), .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (q.ptr),
        .rd_data (rd_data)
    );

    always_comb begin
        d = q;
        if (stop_p) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (start_p) begin
            d.st  = ST_ADDR;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BITS) begin
                        if (q.sh[7:1] == SLV_ADDR) begin
                            d.st = ST_AACK;
                            d.rw = q.sh[0];
                            d.oe = 1'b1;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st = ST_TX;
                            d.sh = rd_data;
                            d.oe = ~rd_data[7];
                        end else begin
                            d.st = ST_WADDR;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WADDR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BITS) begin
                        d.ptr = q.sh[AW-1:0];
                        d.st  = ST_WACK;
                        d.oe  = 1'b1;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        d.st = ST_SKIP;
                        d.oe = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == BITS) begin
                            d.st = ST_TACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        d.ptr  = q.ptr + PTR_ONE;
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st  = ST_TX;
                            d.sh  = rd_data;
                            d.cnt = '0;
                            d.oe  = ~rd_data[7];
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.sh   <= '0;
            q.cnt  <= '0;
            q.ptr  <= '0;
            q.rw   <= 1'b0;
            q.mack <= 1'b0;
            q.oe   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign cur_st  = q.st;
    assign cur_ptr = q.ptr;

endmodule

// File: rtl/i2crd_chk.sv
module i2crd_chk
    import i2crd_pkg::*;
#(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input st_e           st,
    input logic [AW-1:0] ptr
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i); // R10

    AST_ADDR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_ADDR && st == ST_AACK) |-> sda_oe); // R2

    AST_HOST_BIT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TACK) |-> !sda_oe); // R3

    AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_SKIP) |-> !sda_oe); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_TACK && !$stable(ptr)) |-> ptr == $past(ptr) + AW'(1)); // R5

    AST_PTR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> ($past(st) == ST_TACK || $past(st) == ST_WADDR)); // R9

endmodule

bind i2crd_top i2crd_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_oe (sda_oe),
    .st     (cur_st),
    .ptr    (cur_ptr)
);

// File: tb/i2crd_top_bench.sv
`timescale 1ns/1ps
module i2crd_top_bench;
    localparam int         CLK_P = 10;
    localparam logic [6:0] SLV   = 7'h52;
    localparam int         AW    = 5;
    localparam int         DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;

    int n_chk = 0, n_fail = 0;
    int rel_err = 0, r10_err = 0;
    int ptr_m = 0;
    bit mon_rel = 1'b0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;

    assign sda_bus = m_sda & ~sda_oe;

    always #(CLK_P/2) clk = ~clk;

    i2crd_top #(.SLV_ADDR(SLV), .AW(AW)) u_i2crd_top (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    // Per-clock comparison against the expected line ownership.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_rel && sda_oe) rel_err++;
            if (sda_oe != oe_prev && m_scl) r10_err++;
        end
        oe_prev = sda_oe;
    end

    function automatic int pat(int i);
        return (i * 29 + 7) % 256;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clk_bit(input bit mb, input bit rel, output bit s);
        tick(2);
        m_sda = mb;
        tick(6);
        m_scl = 1'b1;
        mon_rel = rel;
        tick(3);
        @(negedge clk);
        s = sda_bus;
        tick(3);
        mon_rel = 1'b0;
        m_scl = 1'b0;
    endtask

    task automatic bus_start();
        tick(2); m_sda = 1'b1;
        tick(6); m_scl = 1'b1;
        tick(6); m_sda = 1'b0;
        tick(6); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(2); m_sda = 1'b0;
        tick(6); m_scl = 1'b1;
        tick(6); m_sda = 1'b1;
        tick(6);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], 1'b1, s);
        clk_bit(1'b1, 1'b0, s);
        ack = !s;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit ack);
        bit s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, 1'b0, s);
            b = {b[6:0], s};
        end
        clk_bit(!ack, 1'b1, s);
    endtask

    task automatic rd_frame(input int n, input bit extra, input string tag);
        bit ack, s, all_hi;
        logic [7:0] b;
        bus_start();
        send_byte({SLV, 1'b1}, ack);
        check(ack, "R2 read address acknowledged", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k < n - 1);
            check(b == 8'(pat(ptr_m)), tag, b, pat(ptr_m));
            ptr_m = (ptr_m + 1) % DEPTH;
        end
        if (extra) begin
            all_hi = 1'b1;
            for (int i = 0; i < 9; i++) begin
                clk_bit(1'b1, 1'b1, s);
                all_hi &= s;
            end
            check(all_hi, "R4 line left high after NACK", all_hi, 1);
        end
        bus_stop();
    endtask

    task automatic set_addr(input logic [7:0] wa);
        bit ack;
        bus_start();
        send_byte({SLV, 1'b0}, ack);
        check(ack, "R7 write address acknowledged", ack, 1);
        send_byte(wa, ack);
        check(ack, "R7 word address acknowledged", ack, 1);
        ptr_m = wa % DEPTH;
    endtask

    initial begin
        bit ack, s;
        tick(5);
        check(sda_oe == 1'b0, "R1 line released in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(5);
        check(sda_oe == 1'b0, "R1 line released after reset", sda_oe, 0);

        rd_frame(4, 1'b0, "R8 download from zero");
        rd_frame(1, 1'b0, "R6 current address read");
        rd_frame(3, 1'b0, "R6 current address burst");

        set_addr(8'd20);
        rd_frame(1, 1'b0, "R7 random read");
        rd_frame(1, 1'b0, "R6 follows random read");

        set_addr(8'd29);
        rd_frame(6, 1'b0, "R5 burst across wrap");

        set_addr(8'hE3);
        rd_frame(2, 1'b0, "R7 upper word bits ignored");

        rd_frame(2, 1'b1, "R4 read before NACK");

        // Foreign address, read direction.
        bus_start();
        send_byte({SLV ^ 7'h01, 1'b1}, ack);
        check(!ack, "R9 foreign read address not acknowledged", ack, 0);
        for (int i = 0; i < 18; i++) clk_bit(1'b1, 1'b1, s);
        bus_stop();
        rd_frame(1, 1'b0, "R9 pointer kept after foreign read");

        // Foreign address, write direction with a word byte.
        bus_start();
        send_byte({SLV ^ 7'h40, 1'b0}, ack);
        check(!ack, "R9 foreign write address not acknowledged", ack, 0);
        send_byte(8'h07, ack);
        check(!ack, "R9 foreign word byte not acknowledged", ack, 0);
        bus_stop();
        rd_frame(1, 1'b0, "R9 pointer kept after foreign write");

        check(rel_err == 0, "R3 line released in host phases", rel_err, 0);
        check(r10_err == 0, "R10 enable moved with clock high", r10_err, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule